// File: doc/BRIEF.md
# Vectored Interrupt Control Unit

This block gathers up to thirteen interrupt request lines from on-chip peripherals and external pins and presents one 3-bit interrupt level to the processor. Each source owns an 8-bit control byte. The byte enables autovectoring for that source and sets its interrupt level and its priority within that level. A single 16-bit mask register can block any source. A read-only pending view shows which raw requests survive the mask.

Software reaches the control bytes, the mask and the pending view through a halfword register port with two byte-lane enables. The port is big-endian: the even byte sits on data bits 15:8. When the processor acknowledges at the presented level, the block registers a response. The response holds the index of the winning source, an autovector flag, and a vector number. The vector is 0x18 plus the level for autovectored sources, or zero with the flag clear when the requesting device must supply its own vector.

Top module: `vic_unit`

## Requirements
- R1: Control byte for source n (1..13) sits at byte address 0x014+n-1, with bit 7 = autovector enable, bits 4:2 = level, bits 1:0 = priority; bits 6:5 read as zero whatever is written.
- R2: After reset the control bytes read 0x04,0x08,0x0C,0x10,0x14,0x18,0x1C,0x1C for sources 1..8, 0x80 for 9..11 and 0x00 for 12..13.
- R3: The mask is a 16-bit register at byte address 0x036 that resets to 0x3FFE; mask bit n set blocks source n.
- R4: Byte address 0x03A reads the pending view: bit n = request n AND NOT mask bit n, with bit 0 and bits 15:14 zero; writes there change nothing.
- R5: A source whose level field is 0 never drives a nonzero interrupt level and never wins arbitration.
- R6: `ipl` equals the highest level among requesting, unmasked, nonzero-level sources, and 0 when there is none; it follows inputs in the same cycle.
- R7: Among eligible sources at the top level, the higher priority field wins; on a full tie the higher source number wins.
- R8: A cycle with `ack_i` high yields `ack_valid` high in the next cycle with `ack_src` = winner index; `ack_valid` is low after any cycle without `ack_i`.
- R9: For an autovectored winner, `ack_auto` = 1 and `ack_vec` = 0x18 + its level.
- R10: For a winner with autovector disabled, `ack_auto` = 0 and `ack_vec` = 0x00.
- R11: Acknowledge with no eligible source returns `ack_src` = 0, `ack_auto` = 1, `ack_vec` = 0x18.
- R12: A write updates only the bytes whose lane enable is set (`bus_be[1]` = even byte on data 15:8, `bus_be[0]` = odd byte on data 7:0); with no lane set nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 13 | Request lines; bit i is source i+1 |
| bus_wr | input | 1 | Register write strobe |
| bus_haddr | input | 9 | Halfword address (byte address divided by two) |
| bus_be | input | 2 | Byte lane enables for writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed halfword |
| ipl | output | 3 | Interrupt level presented to the processor |
| ack_i | input | 1 | Interrupt acknowledge |
| ack_valid | output | 1 | Acknowledge response valid |
| ack_src | output | 4 | Winning source index, 0 if none |
| ack_auto | output | 1 | 1 when the block supplies the vector |
| ack_vec | output | 8 | Vector number |

## Verification
`ipl` and the read data are combinational. The bench checks them at the falling edge after it changes requests or the address, and one cycle after a write has been committed at a rising edge. The acknowledge response is due exactly one rising edge after `ack_i` is sampled. The bench raises `ack_i` at a falling edge and checks the response at the next falling edge. It checks that `ack_valid` is low again one cycle later. An arithmetic model held in the bench tracks every control byte, the mask and the request pattern through a long sweep.

// File: rtl/vic_pkg.sv
package vic_pkg;

   localparam logic [7:0] AUTOVEC_BASE = 8'h18;

   typedef struct packed {
      logic       auto_en;
      logic [2:0] lvl;
      logic [1:0] prio;
   } ctrl_t;

   function automatic logic [7:0] ctrl_to_byte(ctrl_t c);
      return {c.auto_en, 2'b00, c.lvl, c.prio};
   endfunction

   function automatic ctrl_t byte_to_ctrl(logic [7:0] b);
      ctrl_t c;
      c.auto_en = b[7];
      c.lvl     = b[4:2];
      c.prio    = b[1:0];
      return c;
   endfunction

   // Reset image of source n, computed rather than tabulated
   function automatic logic [7:0] ctrl_reset(int n);
      if (n <= 7)       return 8'(4 * n);
      else if (n == 8)  return 8'h1C;
      else if (n <= 11) return 8'h80;
      else              return 8'h00;
   endfunction

endpackage

// File: rtl/vic_regs.sv
module vic_regs
   import vic_pkg::*;
#(
   parameter int          NUM_SRC   = 13,
   parameter int          AW        = 10,
   parameter logic [AW-1:0] CTRL_BASE = 10'h014,
   parameter logic [AW-1:0] MASK_ADDR = 10'h036,
   parameter logic [AW-1:0] PEND_ADDR = 10'h03A
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      wr,
   input  logic [AW-2:0]             haddr,
   input  logic [1:0]                be,
   input  logic [15:0]               wdata,
   input  logic [NUM_SRC-1:0]        req,
   output ctrl_t [NUM_SRC:1]         ctrl,
   output logic [15:0]               mask,
   output logic [15:0]               rdata
);

   localparam logic [AW-2:0] MASK_H = MASK_ADDR[AW-1:1];
   localparam logic [AW-2:0] PEND_H = PEND_ADDR[AW-1:1];

   logic [NUM_SRC:1] hit_even, hit_odd;
   logic [15:0]      pend;

   for (genvar n = 1; n <= NUM_SRC; n++) begin : g_src
      localparam logic [AW-1:0] BA = AW'(int'(CTRL_BASE) + n - 1);
      assign hit_even[n] = (haddr == BA[AW-1:1]) && !BA[0];
      assign hit_odd[n]  = (haddr == BA[AW-1:1]) &&  BA[0];

      always_ff @(posedge clk) begin
         if (!rst_n)
            ctrl[n] <= byte_to_ctrl(ctrl_reset(n));
         else if (wr && hit_even[n] && be[1])
            ctrl[n] <= byte_to_ctrl(wdata[15:8]);
         else if (wr && hit_odd[n] && be[0])
            ctrl[n] <= byte_to_ctrl(wdata[7:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask <= 16'h3FFE;
      end else if (wr && haddr == MASK_H) begin
         if (be[1]) mask[15:8] <= wdata[15:8];
         if (be[0]) mask[7:0]  <= wdata[7:0];
      end
   end

   always_comb begin
      pend = '0;
      for (int n = 1; n <= NUM_SRC; n++)
         pend[n] = req[n-1] & ~mask[n];
   end

   always_comb begin
      rdata = '0;
      for (int n = 1; n <= NUM_SRC; n++) begin
         if (hit_even[n]) rdata[15:8] = rdata[15:8] | ctrl_to_byte(ctrl[n]);
         if (hit_odd[n])  rdata[7:0]  = rdata[7:0]  | ctrl_to_byte(ctrl[n]);
      end
      if (haddr == MASK_H) rdata = rdata | mask;
      if (haddr == PEND_H) rdata = rdata | pend;
   end

endmodule

// File: rtl/vic_arb.sv
module vic_arb
   import vic_pkg::*;
#(
   parameter int NUM_SRC  = 13,
   parameter bit TIE_HIGH = 1'b1,
   localparam int SW      = $clog2(NUM_SRC + 1)
) (
   input  ctrl_t [NUM_SRC:1]  ctrl,
   input  logic [15:0]        mask,
   input  logic [NUM_SRC-1:0] req,
   output logic [SW-1:0]      win_src,
   output logic [2:0]         win_lvl,
   output logic               win_auto
);

   logic [NUM_SRC:1] elig;

   for (genvar n = 1; n <= NUM_SRC; n++) begin : g_elig
      assign elig[n] = req[n-1] & ~mask[n] & (ctrl[n].lvl != 3'd0);
   end

   logic [4:0] best_key;

   if (TIE_HIGH) begin : g_tie_high
      always_comb begin
         best_key = '0;
         win_src  = '0;
         for (int n = 1; n <= NUM_SRC; n++)
            if (elig[n] && {ctrl[n].lvl, ctrl[n].prio} >= best_key) begin
               best_key = {ctrl[n].lvl, ctrl[n].prio};
               win_src  = SW'(n);
            end
      end
   end else begin : g_tie_low
      always_comb begin
         best_key = '0;
         win_src  = '0;
         for (int n = 1; n <= NUM_SRC; n++)
            if (elig[n] && {ctrl[n].lvl, ctrl[n].prio} > best_key) begin
               best_key = {ctrl[n].lvl, ctrl[n].prio};
               win_src  = SW'(n);
            end
      end
   end

   always_comb begin
      win_lvl  = best_key[4:2];
      win_auto = 1'b1;
      for (int n = 1; n <= NUM_SRC; n++)
         if (win_src == SW'(n)) win_auto = ctrl[n].auto_en;
   end

endmodule

// File: rtl/vic_ack.sv
module vic_ack
   import vic_pkg::*;
#(
   parameter int SW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ack_i,
   input  logic [SW-1:0] win_src,
   input  logic [2:0]    win_lvl,
   input  logic          win_auto,
   output logic          ack_valid,
   output logic [SW-1:0] ack_src,
   output logic          ack_auto,
   output logic [7:0]    ack_vec
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ack_valid <= 1'b0;
         ack_src   <= '0;
         ack_auto  <= 1'b0;
         ack_vec   <= '0;
      end else begin
         ack_valid <= ack_i;
         if (ack_i) begin
            ack_src  <= win_src;
            ack_auto <= win_auto;
            ack_vec  <= win_auto ? AUTOVEC_BASE + {5'd0, win_lvl} : 8'h00;
         end
      end
   end

endmodule

// File: rtl/vic_unit.sv
module vic_unit
   import vic_pkg::*;
#(
   parameter int NUM_SRC  = 13,
   parameter int AW       = 10,
   parameter bit TIE_HIGH = 1'b1,
   localparam int SW      = $clog2(NUM_SRC + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_req,
   input  logic               bus_wr,
   input  logic [AW-2:0]      bus_haddr,
   input  logic [1:0]         bus_be,
   input  logic [15:0]        bus_wdata,
   output logic [15:0]        bus_rdata,
   output logic [2:0]         ipl,
   input  logic               ack_i,
   output logic               ack_valid,
   output logic [SW-1:0]      ack_src,
   output logic               ack_auto,
   output logic [7:0]         ack_vec
);

   if (NUM_SRC < 1 || NUM_SRC > 15) begin : g_bad_src
      $error("vic_unit: NUM_SRC must lie in 1..15");
   end
   if (AW < 7) begin : g_bad_aw
      $error("vic_unit: AW too narrow for the register map");
   end

   ctrl_t [NUM_SRC:1] ctrl;
   logic [15:0]       mask;
   logic [SW-1:0]     win_src;
   logic [2:0]        win_lvl;
   logic              win_auto;

   vic_regs #(.NUM_SRC(NUM_SRC), .AW(AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .haddr(bus_haddr), .be(bus_be),
      .wdata(bus_wdata), .req(src_req), .ctrl(ctrl), .mask(mask), .rdata(bus_rdata)
   );

   vic_arb #(.NUM_SRC(NUM_SRC), .TIE_HIGH(TIE_HIGH)) u_arb (
      .ctrl(ctrl), .mask(mask), .req(src_req),
      .win_src(win_src), .win_lvl(win_lvl), .win_auto(win_auto)
   );

   assign ipl = win_lvl;

   vic_ack #(.SW(SW)) u_ack (
      .clk(clk), .rst_n(rst_n), .ack_i(ack_i),
      .win_src(win_src), .win_lvl(win_lvl), .win_auto(win_auto),
      .ack_valid(ack_valid), .ack_src(ack_src), .ack_auto(ack_auto), .ack_vec(ack_vec)
   );

endmodule

// File: rtl/vic_unit_chk.sv
module vic_unit_chk #(
   parameter int NUM_SRC = 13,
   parameter int SW      = 4
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_SRC-1:0] src_req,
   input logic [2:0]         ipl,
   input logic               ack_i,
   input logic               ack_valid,
   input logic [SW-1:0]      ack_src,
   input logic               ack_auto,
   input logic [7:0]         ack_vec
);

   AST_IPL_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (ipl != 3'd0) |-> ($countones(src_req) != 0));                          // R6

   AST_ACK_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      ack_i |=> ack_valid);                                                  // R8

   AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_i |=> !ack_valid);                                                // R8

   AST_AUTO_VEC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ipl != 3'd0) |=> (!ack_auto || ack_vec == 8'h18 + {5'd0, $past(ipl)})); // R9

   AST_EXT_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !ack_auto) |-> (ack_vec == 8'h00));                      // R10

   AST_SRC_WHEN_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ipl != 3'd0) |=> (ack_src != '0));                           // R11

   AST_NONE_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && ipl == 3'd0) |=> (ack_src == '0 && ack_auto && ack_vec == 8'h18)); // R11

endmodule

bind vic_unit vic_unit_chk #(.NUM_SRC(NUM_SRC), .SW(SW)) u_chk (
   .clk(clk), .rst_n(rst_n), .src_req(src_req), .ipl(ipl), .ack_i(ack_i),
   .ack_valid(ack_valid), .ack_src(ack_src), .ack_auto(ack_auto), .ack_vec(ack_vec)
);

// File: tb/vic_unit_test.sv
`timescale 1ns/1ps
module vic_unit_test;

   localparam int N = 13;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src_req = '0;
   logic        bus_wr = 1'b0;
   logic [8:0]  bus_haddr = '0;
   logic [1:0]  bus_be = '0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [2:0]  ipl;
   logic        ack_i = 1'b0;
   logic        ack_valid;
   logic [3:0]  ack_src;
   logic        ack_auto;
   logic [7:0]  ack_vec;

   int checks = 0;
   int fails  = 0;
   int cycles = 0;

   logic [7:0]  m_ctrl [1:N];
   logic [15:0] m_mask;

   vic_unit uut (
      .clk(clk), .rst_n(rst_n), .src_req(src_req), .bus_wr(bus_wr),
      .bus_haddr(bus_haddr), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .ipl(ipl), .ack_i(ack_i), .ack_valid(ack_valid),
      .ack_src(ack_src), .ack_auto(ack_auto), .ack_vec(ack_vec)
   );

   always #2 clk = ~clk;

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         checks++; fails++;
         $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
         summary();
         $finish;
      end
   end

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(int baddr, logic [15:0] d, logic [1:0] be);
      @(negedge clk);
      bus_wr = 1'b1; bus_haddr = 9'(baddr >> 1); bus_be = be; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = 2'b00;
   endtask

   task automatic wr_ctrl(int n, logic [7:0] v);
      int a = 'h14 + n - 1;
      if (a % 2 == 0) wr(a, {v, 8'h00}, 2'b10);
      else            wr(a, {8'h00, v}, 2'b01);
      m_ctrl[n] = v & 8'h9F;
   endtask

   task automatic rd(int baddr, output logic [15:0] d);
      bus_haddr = 9'(baddr >> 1);
      #1 d = bus_rdata;
   endtask

   task automatic chk_ctrl(string req, int n);
      logic [15:0] d;
      int a = 'h14 + n - 1;
      rd(a, d);
      chk(req, (a % 2 == 0) ? int'(d[15:8]) : int'(d[7:0]), int'(m_ctrl[n]));
   endtask

   function automatic int model_win();
      int best = 0, bkey = 0;
      for (int n = 1; n <= N; n++) begin
         int key = (int'(m_ctrl[n][4:2]) << 2) | int'(m_ctrl[n][1:0]);
         if (src_req[n-1] && !m_mask[n] && m_ctrl[n][4:2] != 0 && key >= bkey) begin
            best = n; bkey = key;
         end
      end
      return best;
   endfunction

   // Checks ipl, pending view, and one acknowledge cycle against the model
   task automatic check_state(string tag);
      logic [15:0] d, ep;
      int w, lv, au, vec;
      @(negedge clk);
      w  = model_win();
      lv = (w == 0) ? 0 : int'(m_ctrl[w][4:2]);
      au = (w == 0) ? 1 : int'(m_ctrl[w][7]);
      vec = au ? ('h18 + lv) : 0;
      ep = '0;
      for (int n = 1; n <= N; n++) ep[n] = src_req[n-1] & ~m_mask[n];
      chk({tag, " R6 ipl"}, int'(ipl), lv);
      rd('h3A, d);
      chk({tag, " R4 pend"}, int'(d), int'(ep));
      ack_i = 1'b1;
      @(negedge clk);
      ack_i = 1'b0;
      chk({tag, " R8 valid"}, int'(ack_valid), 1);
      chk({tag, " R7 src"}, int'(ack_src), w);
      chk({tag, (au ? " R9 auto" : " R10 auto")}, int'(ack_auto), au);
      chk({tag, (w == 0 ? " R11 vec" : (au ? " R9 vec" : " R10 vec"))}, int'(ack_vec), vec);
      @(negedge clk);
      chk({tag, " R8 drop"}, int'(ack_valid), 0);
   endtask

   initial begin
      logic [15:0] d;
      for (int n = 1; n <= N; n++)
         m_ctrl[n] = (n <= 7) ? 8'(4 * n) : (n == 8) ? 8'h1C : (n <= 11) ? 8'h80 : 8'h00;
      m_mask = 16'h3FFE;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // Reset state
      for (int n = 1; n <= N; n++) chk_ctrl("R2 reset ctrl", n);
      rd('h36, d);
      chk("R3 reset mask", int'(d), 'h3FFE);
      src_req = '1;
      #1 chk("R3 all masked ipl", int'(ipl), 0);
      check_state("reset");

      // Unused control bits and lane isolation
      wr_ctrl(5, 8'hFF);
      chk_ctrl("R1 bits6:5 zero", 5);
      chk_ctrl("R1 neighbour kept", 6);
      wr('h18, 16'h0000, 2'b00);
      chk_ctrl("R12 no lane src5", 5);
      chk_ctrl("R12 no lane src6", 6);
      wr('h36, 16'h0000, 2'b01);
      m_mask[7:0] = 8'h00;
      rd('h36, d);
      chk("R12 low lane mask", int'(d), int'(m_mask));
      wr('h36, 16'h0000, 2'b10);
      m_mask = 16'h0000;

      // Pending is read-only
      wr('h3A, 16'hFFFF, 2'b11);
      src_req = '0;
      rd('h3A, d);
      chk("R4 pend write ignored", int'(d), 0);
      src_req = '1;
      rd('h3A, d);
      chk("R4 pend all", int'(d), 'h3FFE);
      rd('h36, d);
      chk("R4 mask untouched", int'(d), 0);

      // Level 0 never requests
      for (int n = 1; n <= N; n++) wr_ctrl(n, 8'h00);
      wr_ctrl(4, 8'h83);
      #1 chk("R5 level0 ipl", int'(ipl), 0);
      check_state("R5");

      // Full tie: higher source wins
      wr_ctrl(3, 8'h8D);
      wr_ctrl(10, 8'h8D);
      src_req = 13'b0_0010_0000_0100;
      check_state("R7 tie");
      #1 chk("R7 tie winner", int'(ack_src), 10);
      wr_ctrl(3, 8'h8E);
      check_state("R7 prio");
      // Device-supplied vector
      wr_ctrl(3, 8'h0E);
      check_state("R10");
      src_req = '0;
      check_state("R11");
      // Mask blocks a single source
      src_req = 13'b0_0010_0000_0100;
      wr('h36, 16'h0008, 2'b11);
      m_mask = 16'h0008;
      check_state("R3 mask3");

      // Sweep
      for (int t = 0; t < 400; t++) begin
         int n = 1 + ($urandom % N);
         wr_ctrl(n, 8'($urandom));
         if (t % 3 == 0) begin
            logic [15:0] mv = 16'($urandom) & 16'($urandom);
            wr('h36, mv, 2'b11);
            m_mask = mv;
         end
         src_req = 13'($urandom);
         check_state("sweep");
         if (t % 50 == 0) chk_ctrl("R1 sweep ctrl", n);
      end

      summary();
      $finish;
   end

endmodule